// File: doc/BRIEF.md
# Framed Elastic Store with Slip Control

This block carries a serial PCM bit stream from a receive clock domain into a system clock domain whose frequency is nominally equal but drifts. Receive bits are written into a memory that holds two frames. System bits are read from it one frame at a time. Each side keeps its own frame position counter. A strobe on each side marks bit 0 of a frame, and the counter wraps by itself when no strobe arrives. A bit therefore leaves the store at the same frame position it entered.

The read side makes every decision at its own frame boundary. It looks at the synchronized write pointer and measures how far the writer has advanced into the frame that is about to be read. If the writer is close to lapping the reader, or has barely started that frame, the read side chooses the other frame half. This is a slip: one whole frame is dropped or repeated, and the depth returns to about one frame. Each slip drives an active-low pulse and records its direction. A falling edge on the align input requests the same recentering at the next boundary without reporting a slip.

Typical frame sizes are 192 payload bits (a 48-byte store) and 256 bits (a 64-byte store).

Top module: `pcm_elastic_store`

## Requirements
- R1: While `sys_rst` is high, and in the first cycle after it, `slip_n` is 1 and `slip_dir` is 0.
- R2: The store holds 2*FRAME_BITS bits. `rx_data` is sampled on the falling edge of `rx_clk`, and `sys_data` changes on the rising edge of `sys_clk`. A strobe (`rx_fs` or `sys_fs`) high on the sampling edge marks bit 0 of a frame. The bit output at system frame position p is the receive bit from frame position p.
- R3: After reset the store starts about one frame deep. With equal clock rates no slip ever occurs.
- R4: `slip_n` falls only on the rising `sys_clk` edge that launches bit 0 of a system frame.
- R5: If the synchronized write pointer is within GUARD bits of lapping the next frame to be read, the store slips that frame (overflow, one frame dropped) and sets `slip_dir` to 1. The depth returns to about one frame.
- R6: If the writer is fewer than GUARD bits into the next frame to be read, the store reads the previous frame again (underflow, one frame repeated) and sets `slip_dir` to 0.
- R7: Each slip holds `slip_n` low for exactly SLIP_LEN (65) system cycles. A slip that occurs during a pulse restarts the count.
- R8: `slip_dir` changes only together with a slip and keeps its value until the next slip.
- R9: A falling edge on `align_n` is passed through a two-flop synchronizer. At the next system frame boundary the read side then chooses the frame half whose depth lies in [FRAME_BITS/2, 3*FRAME_BITS/2). This produces no `slip_n` pulse and leaves `slip_dir` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive bit clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_data | input | 1 | Receive serial data, sampled on the falling edge of rx_clk |
| rx_fs | input | 1 | Receive frame strobe; high marks bit 0 |
| sys_clk | input | 1 | System bit clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| sys_fs | input | 1 | System frame strobe; high marks the launch of bit 0 |
| align_n | input | 1 | Asynchronous align request, acts on a falling edge |
| sys_data | output | 1 | System serial data, registered |
| slip_n | output | 1 | Active-low slip pulse, SLIP_LEN cycles long |
| slip_dir | output | 1 | Direction of the last slip: 1 overflow, 0 underflow |

## Verification
The assertions assume that both frame strobes agree with the natural wrap of their counters, so the write pointer steps by one position at a time. They also assume that `align_n` rises again before another falling edge is needed and that the two clock rates differ by only a few percent. The bench pulses each strobe exactly once per frame and keeps the receive clock within two percent of the system clock. It drives `align_n` low for three system cycles out of every sixty, so a request is never merged with the previous one. Under these conditions the slip pulses are spaced far beyond SLIP_LEN, and every pulse can be measured at its full length.

// File: rtl/es_pkg.sv
package es_pkg;

  typedef enum logic {
    SLIP_UNDER = 1'b0,
    SLIP_OVER  = 1'b1
  } slip_dir_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/es_dpram.sv
module es_dpram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic          rd_clk,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_data
);

  logic mem [DEPTH];

  // Receive bits are captured on the falling edge of the receive clock.
  always_ff @(negedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port; this register also serves as the serial output flop.
  always_ff @(posedge rd_clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/es_wr_side.sv
module es_wr_side
  import es_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int AW         = 9,
  parameter int POSW       = 8,
  parameter int BASE       = 0
) (
  input  logic          rx_clk,
  input  logic          rx_rst,
  input  logic          rx_fs,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wr_gray
);

  localparam int          D         = 2 * FRAME_BITS;
  localparam logic [AW-1:0] GRAY_RST = AW'(bin_to_gray(32'(D - 1 + BASE)));

  logic [POSW-1:0] pos_q, pos_d;
  logic            half_q, half_d;

  always_comb begin
    if (rx_fs || pos_q == POSW'(FRAME_BITS - 1)) pos_d = '0;
    else                                          pos_d = pos_q + 1'b1;
    half_d  = (pos_d == '0) ? ~half_q : half_q;
    wr_addr = half_d ? AW'(FRAME_BITS + int'(pos_d)) : AW'(pos_d);
    wr_en   = !rx_rst;
  end

  // The pointer is offset by BASE so that the wrap from the last position
  // back to the first also changes a single Gray bit.
  always_ff @(negedge rx_clk) begin
    if (rx_rst) begin
      pos_q   <= POSW'(FRAME_BITS - 1);
      half_q  <= 1'b1;
      wr_gray <= GRAY_RST;
    end else begin
      pos_q   <= pos_d;
      half_q  <= half_d;
      wr_gray <= AW'(bin_to_gray(32'(wr_addr) + 32'(BASE)));
    end
  end

endmodule

// File: rtl/es_ptr_sync.sv
module es_ptr_sync
  import es_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int AW         = 9,
  parameter int BASE       = 0
) (
  input  logic          sys_clk,
  input  logic          sys_rst,
  input  logic [AW-1:0] wr_gray,
  output logic [AW-1:0] wr_ptr
);

  localparam int          D         = 2 * FRAME_BITS;
  localparam logic [AW-1:0] GRAY_RST = AW'(bin_to_gray(32'(D - 1 + BASE)));

  logic [AW-1:0] meta_q, sync_q;

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      meta_q <= GRAY_RST;
      sync_q <= GRAY_RST;
    end else begin
      meta_q <= wr_gray;
      sync_q <= meta_q;
    end
  end

  assign wr_ptr = AW'(gray_to_bin(32'(sync_q)) - 32'(BASE));

endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
  import es_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int AW         = 9,
  parameter int POSW       = 8,
  parameter int GUARD      = 8,
  parameter int SLIP_LEN   = 65
) (
  input  logic          sys_clk,
  input  logic          sys_rst,
  input  logic          sys_fs,
  input  logic          align_n,
  input  logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr,
  output logic          frame_start,
  output logic          align_done,
  output logic          slip_n,
  output logic          slip_dir
);

  localparam int D  = 2 * FRAME_BITS;
  localparam int CW = $clog2(SLIP_LEN + 1);
  localparam int LO = FRAME_BITS / 2;
  localparam int HI = FRAME_BITS + FRAME_BITS / 2;

  logic [POSW-1:0] pos_q, pos_d;
  logic            half_q, half_d;
  logic [CW-1:0]   cnt_q;
  logic [2:0]      aln_q;
  logic            pend_q;
  logic            aln_fall;
  logic            take;
  slip_dir_e       dir_q, dir_d;
  int              rbase, dep_c;

  assign aln_fall = aln_q[2] & ~aln_q[1];

  always_comb begin
    if (sys_fs || pos_q == POSW'(FRAME_BITS - 1)) pos_d = '0;
    else                                           pos_d = pos_q + 1'b1;
    frame_start = (pos_d == '0);

    // Depth seen from the start of the normally next frame half.
    rbase = half_q ? 0 : FRAME_BITS;
    dep_c = (int'(wr_ptr) - rbase + D) % D;

    half_d     = half_q;
    take       = 1'b0;
    dir_d      = dir_q;
    align_done = 1'b0;
    if (frame_start) begin
      if (pend_q) begin
        align_done = 1'b1;
        half_d     = (dep_c >= LO && dep_c < HI) ? ~half_q : half_q;
      end else if (dep_c < GUARD) begin
        take  = 1'b1;
        dir_d = SLIP_UNDER;
      end else if (dep_c >= D - GUARD) begin
        take  = 1'b1;
        dir_d = SLIP_OVER;
      end else begin
        half_d = ~half_q;
      end
    end

    rd_addr = half_d ? AW'(FRAME_BITS + int'(pos_d)) : AW'(pos_d);
  end

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      pos_q  <= POSW'(FRAME_BITS - 1);
      half_q <= 1'b0;
      aln_q  <= 3'b111;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      slip_n <= 1'b1;
      dir_q  <= SLIP_UNDER;
    end else begin
      pos_q  <= pos_d;
      half_q <= half_d;
      aln_q  <= {aln_q[1:0], align_n};
      if (aln_fall)        pend_q <= 1'b1;
      else if (align_done) pend_q <= 1'b0;
      dir_q <= dir_d;
      if (take) begin
        cnt_q  <= CW'(SLIP_LEN - 1);
        slip_n <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        slip_n <= 1'b0;
      end else begin
        slip_n <= 1'b1;
      end
    end
  end

  assign slip_dir = dir_q;

endmodule

// File: rtl/pcm_elastic_store.sv
module pcm_elastic_store #(
  parameter int FRAME_BITS = 256,
  parameter int GUARD      = 8,
  parameter int SLIP_LEN   = 65
) (
  input  logic rx_clk,
  input  logic rx_rst,
  input  logic rx_data,
  input  logic rx_fs,
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic sys_fs,
  input  logic align_n,
  output logic sys_data,
  output logic slip_n,
  output logic slip_dir
);

  localparam int D    = 2 * FRAME_BITS;
  localparam int AW   = $clog2(D);
  localparam int POSW = $clog2(FRAME_BITS);
  localparam int BASE = (1 << (AW - 1)) - FRAME_BITS;

  logic          wr_en;
  logic [AW-1:0] wr_addr, wr_gray, wr_ptr_sys, rd_addr;
  logic          rd_frame_start, rd_align_done;

  es_wr_side #(
    .FRAME_BITS(FRAME_BITS), .AW(AW), .POSW(POSW), .BASE(BASE)
  ) wr_i (
    .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_fs(rx_fs),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray)
  );

  es_ptr_sync #(
    .FRAME_BITS(FRAME_BITS), .AW(AW), .BASE(BASE)
  ) sync_i (
    .sys_clk(sys_clk), .sys_rst(sys_rst),
    .wr_gray(wr_gray), .wr_ptr(wr_ptr_sys)
  );

  es_rd_ctrl #(
    .FRAME_BITS(FRAME_BITS), .AW(AW), .POSW(POSW),
    .GUARD(GUARD), .SLIP_LEN(SLIP_LEN)
  ) rd_i (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_fs(sys_fs), .align_n(align_n),
    .wr_ptr(wr_ptr_sys), .rd_addr(rd_addr), .frame_start(rd_frame_start),
    .align_done(rd_align_done), .slip_n(slip_n), .slip_dir(slip_dir)
  );

  es_dpram #(.DEPTH(D), .AW(AW)) ram_i (
    .wr_clk(rx_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(rx_data),
    .rd_clk(sys_clk), .rd_addr(rd_addr), .rd_data(sys_data)
  );

endmodule

// File: rtl/es_checker.sv
module es_checker #(
  parameter int SLIP_LEN = 65
) (
  input logic sys_clk,
  input logic sys_rst,
  input logic slip_n,
  input logic slip_dir,
  input logic frame_start,
  input logic align_done
);

  int   low_run;
  logic rst_seen;

  always_ff @(posedge sys_clk) begin
    rst_seen <= sys_rst;
    if (sys_rst)     low_run <= 0;
    else if (slip_n) low_run <= 0;
    else             low_run <= low_run + 1;
  end

  // R1: outputs idle during and right after reset
  always @(negedge sys_clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_idle_r1: assert (slip_n === 1'b1 && slip_dir === 1'b0);
    end
  end

  p_fall_on_frame_r4: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $fell(slip_n) |-> $past(frame_start));

  p_pulse_len_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $rose(slip_n) |-> low_run >= SLIP_LEN);

  p_dir_hold_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !$stable(slip_dir) |-> !slip_n);

  p_align_quiet_r9: assert property (@(posedge sys_clk) disable iff (sys_rst)
    align_done |=> !$fell(slip_n));

endmodule

bind pcm_elastic_store es_checker #(.SLIP_LEN(SLIP_LEN)) chk_i (
  .sys_clk(sys_clk), .sys_rst(sys_rst), .slip_n(slip_n), .slip_dir(slip_dir),
  .frame_start(rd_frame_start), .align_done(rd_align_done)
);

// File: tb/pcm_elastic_store_tb_top.sv
`timescale 1ns/1ps
module pcm_elastic_store_tb_top;

  localparam int F        = 16;
  localparam int GUARD    = 6;
  localparam int SLIP_LEN = 65;

  logic rx_clk = 1'b0, rx_rst = 1'b1, rx_data = 1'b0, rx_fs = 1'b0;
  logic sys_clk = 1'b0, sys_rst = 1'b1, sys_fs = 1'b0, align_n = 1'b1;
  logic sys_data, slip_n, slip_dir;

  realtime rx_half = 2.5;
  bit      go = 1'b0;
  bit      done = 1'b0;
  int      n_chk = 0, n_fail = 0;

  pcm_elastic_store #(.FRAME_BITS(F), .GUARD(GUARD), .SLIP_LEN(SLIP_LEN)) dut_i (
    .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_data(rx_data), .rx_fs(rx_fs),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_fs(sys_fs), .align_n(align_n),
    .sys_data(sys_data), .slip_n(slip_n), .slip_dir(slip_dir)
  );

  initial forever #2.5 sys_clk = ~sys_clk;
  initial begin
    #1.1;
    forever #(rx_half) rx_clk = ~rx_clk;
  end

  function automatic logic pat(input int p);
    logic [7:0] v;
    v = 8'(p * 37 + 11);
    return ^v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Receive driver: inputs change on the rising edge, sampled on the falling one.
  initial begin
    int wp;
    wp = 0;
    wait (go);
    @(posedge rx_clk);
    rx_rst = 1'b0;
    forever begin
      rx_fs   = (wp == 0);
      rx_data = pat(wp);
      wp      = (wp + 1) % F;
      @(posedge rx_clk);
    end
  end

  int   e = -1;
  logic prev_sn = 1'b1;
  logic prev_dir = 1'b0;
  int   run = 0;

  // mode 0: equal rates, 1: receive fast, 2: receive slow, 3: slow plus align
  task automatic run_phase(input int ncyc, input int mode, output int nslip);
    nslip = 0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      @(negedge sys_clk);
      e++;
      if (prev_sn && !slip_n) begin
        chk((e % F) == 0, "R4", "slip edge frame position", e % F, 0);
        if (mode == 1) chk(slip_dir == 1'b1, "R5", "overflow direction", int'(slip_dir), 1);
        if (mode == 2) chk(slip_dir == 1'b0, "R6", "underflow direction", int'(slip_dir), 0);
        if (mode != 3 || cyc >= 100) nslip++;
      end
      if (!prev_sn && slip_n) begin
        chk(run == SLIP_LEN, "R7", "slip pulse width", run, SLIP_LEN);
        run = 0;
      end
      if (!slip_n) run++;
      if (slip_dir !== prev_dir)
        chk(!slip_n, "R8", "direction changed without slip", int'(slip_n), 0);
      if (e >= 4 * F)
        chk(sys_data === pat(e % F), "R2", "output bit at frame position",
            int'(sys_data), int'(pat(e % F)));
      prev_sn  = slip_n;
      prev_dir = slip_dir;
      sys_fs   = (((e + 1) % F) == 0);
      align_n  = (mode == 3) ? !((cyc % 60) < 3) : 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int ns;
    repeat (8) @(negedge sys_clk);
    chk(slip_n === 1'b1, "R1", "slip_n in reset", int'(slip_n), 1);
    chk(slip_dir === 1'b0, "R1", "slip_dir in reset", int'(slip_dir), 0);
    sys_rst = 1'b0;
    sys_fs  = 1'b1;
    go      = 1'b1;
    @(negedge sys_clk);
    e = 0;
    chk(slip_n === 1'b1, "R1", "slip_n after reset", int'(slip_n), 1);
    chk(slip_dir === 1'b0, "R1", "slip_dir after reset", int'(slip_dir), 0);
    sys_fs = 1'b0;

    rx_half = 2.5;
    run_phase(3000, 0, ns);
    chk(ns == 0, "R3", "slips at equal rates", ns, 0);

    rx_half = 2.45;
    run_phase(6000, 1, ns);
    chk(ns >= 2, "R5", "overflow slips with fast receive", ns, 2);
    chk(slip_dir == 1'b1, "R8", "direction held after overflow", int'(slip_dir), 1);

    rx_half = 2.55;
    run_phase(6000, 2, ns);
    chk(ns >= 2, "R6", "underflow slips with slow receive", ns, 2);
    chk(slip_dir == 1'b0, "R8", "direction held after underflow", int'(slip_dir), 0);

    run_phase(5000, 3, ns);
    chk(ns == 0, "R9", "slips while align recenters", ns, 0);
    chk(slip_dir == 1'b0, "R9", "direction unchanged by align", int'(slip_dir), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule